// File: doc/BRIEF.md
# Private Timer Interrupt Edge Capture

This block sits between the per-core timer and watchdog units and the interrupt controller. Each core owns two level-type sources: a timer and a watchdog. The block watches every source for a low-to-high transition. On such a transition it latches a pending flag for one of two banked private interrupt IDs on the core that the source belongs to. The flag stays set until the controller clears it with a per-flag clear strobe. Priority resolution and delivery to cores happen elsewhere.

The source index fixes the routing. Source `i` belongs to core `i >> 1`. An even source is a timer and sets private ID 29. An odd source is a watchdog and sets private ID 30. The core count is a parameter from 1 to 4. The ports are always sized for four cores. The source inputs of cores beyond the configured count are treated as unwired.

Top module: `pti_edge_capture`

## Requirements
- R1: A synchronous reset clears every pending flag and every stored previous level to 0. A source that is high when reset is released therefore counts as a rising edge on the first clock after release.
- R2: A source that is low in its stored previous level and high at a clock edge sets its pending flag. The flag is visible right after that edge.
- R3: A level that stays high sets its flag only once. After a clear, a source held high does not set the flag again.
- R4: A falling edge or a steady low level leaves a pending flag unchanged. A set flag holds until it is cleared.
- R5: Pending bit `2c` is core `c`'s ID 29 (timer) flag and is set by source `2c`. Pending bit `2c+1` is core `c`'s ID 30 (watchdog) flag and is set by source `2c+1`. The clear strobe at bit `n` clears pending bit `n`.
- R6: The previous level is recorded on every clock, whether or not an edge is seen. After the level falls and then rises again, a cleared flag is set again.
- R7: Sources and clears of cores at or above the configured core count have no effect. Their pending bits and any-pending outputs stay 0.
- R8: A clear strobe drops only its own flag. The drop is visible right after the clock edge on which the strobe is sampled.
- R9: If a clear and a rising edge reach the same flag on the same clock edge, the flag ends set.
- R10: `any_pend[c]` is high exactly when at least one of core `c`'s two pending bits is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 8 | Source levels; bit `2c` is core `c`'s timer, bit `2c+1` is core `c`'s watchdog |
| clr_req | input | 8 | Per-flag clear strobes, with the same bit layout as `pend` |
| pend | output | 8 | Pending flags; bit `2c` is ID 29 and bit `2c+1` is ID 30 of core `c` |
| any_pend | output | 4 | Per-core OR of that core's two pending flags |

## Verification
Every result is due exactly one clock edge after its stimulus. A level change or clear strobe sampled on edge `k` shows on `pend` and `any_pend` right after edge `k`, because a single register stage holds the pending flags. The bench changes inputs on the falling edge and reads the outputs on the following falling edge. Each read therefore sees the effect of exactly one rising edge. A reset release shows its effect the same way, one edge after the release. The bench builds the block with three cores, so the fourth core's unwired inputs can be driven and shown to have no effect.

// File: rtl/pti_pkg.sv
package pti_pkg;

    localparam int MAX_CORES    = 4;
    localparam int SRC_PER_CORE = 2;
    localparam int MAX_SRC      = MAX_CORES * SRC_PER_CORE;
    localparam int CORE_W       = $clog2(MAX_CORES);

    // Banked private interrupt IDs carried by the two slots of a core
    localparam logic [4:0] ID_TIMER = 5'd29;
    localparam logic [4:0] ID_WDOG  = 5'd30;

    typedef enum logic {
        SLOT_TIMER = 1'b0,
        SLOT_WDOG  = 1'b1
    } slot_e;

    // Target core of a source index
    function automatic int src_core(input int s);
        return s / SRC_PER_CORE;
    endfunction

    // Slot (timer or watchdog) of a source index
    function automatic int src_slot(input int s);
        return s % SRC_PER_CORE;
    endfunction

    // Private ID that a slot raises
    function automatic logic [4:0] slot_id(input slot_e sl);
        return (sl == SLOT_WDOG) ? ID_WDOG : ID_TIMER;
    endfunction

endpackage

// File: rtl/pti_src_edge.sv
module pti_src_edge #(
    parameter bit USED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    generate
        if (USED) begin : g_live
            logic prev_q;

            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= lvl;
            end

            assign rise = lvl & ~prev_q;

            // A rise stores a high level, so the very next cycle cannot rise
            AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (rst)
                rise |=> !rise); // R3
        end else begin : g_dead
            logic unused_in;
            assign unused_in = ^{clk, rst, lvl};
            assign rise      = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pti_core_pend.sv
module pti_core_pend
    import pti_pkg::*;
#(
    parameter bit USED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SRC_PER_CORE-1:0] rise,
    input  logic [SRC_PER_CORE-1:0] clr,
    output logic [SRC_PER_CORE-1:0] pend,
    output logic                    any
);

    generate
        if (USED) begin : g_live
            logic [SRC_PER_CORE-1:0] pend_q;
            logic [SRC_PER_CORE-1:0] pend_d;

            // A new edge wins over a clear on the same flag
            always_comb begin
                pend_d = (pend_q & ~clr) | rise;
            end

            always_ff @(posedge clk) begin
                if (rst) pend_q <= '0;
                else     pend_q <= pend_d;
            end

            assign pend = pend_q;
            assign any  = |pend_q;

            for (genvar k = 0; k < SRC_PER_CORE; k++) begin : g_chk
                AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
                    rise[k] |=> pend_q[k]); // R2
                AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
                    (clr[k] && !rise[k]) |=> !pend_q[k]); // R8
                AST_HOLD_SET: assert property (@(posedge clk) disable iff (rst)
                    (pend_q[k] && !clr[k]) |=> pend_q[k]); // R4
                AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
                    (!pend_q[k] && !rise[k]) |=> !pend_q[k]); // R3
            end
        end else begin : g_dead
            logic unused_in;
            assign unused_in = ^{clk, rst, rise, clr};
            assign pend      = '0;
            assign any       = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pti_edge_capture.sv
module pti_edge_capture
    import pti_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MAX_SRC-1:0]   src_lvl,
    input  logic [MAX_SRC-1:0]   clr_req,
    output logic [MAX_SRC-1:0]   pend,
    output logic [MAX_CORES-1:0] any_pend
);

    localparam int NUM_SRC = NUM_CORES * SRC_PER_CORE;

    logic [MAX_SRC-1:0]                       rise;
    logic [MAX_CORES-1:0][SRC_PER_CORE-1:0]   core_rise;

    generate
        // One edge detector per source; unwired sources are tied off
        for (genvar s = 0; s < MAX_SRC; s++) begin : g_src
            pti_src_edge #(
                .USED (s < NUM_SRC)
            ) u_edge (
                .clk  (clk),
                .rst  (rst),
                .lvl  (src_lvl[s]),
                .rise (rise[s])
            );
            // Source index splits into target core and banked slot
            assign core_rise[src_core(s)][src_slot(s)] = rise[s];
        end

        for (genvar c = 0; c < MAX_CORES; c++) begin : g_core
            pti_core_pend #(
                .USED (c < NUM_CORES)
            ) u_pend (
                .clk  (clk),
                .rst  (rst),
                .rise (core_rise[c]),
                .clr  (clr_req[c*SRC_PER_CORE +: SRC_PER_CORE]),
                .pend (pend[c*SRC_PER_CORE +: SRC_PER_CORE]),
                .any  (any_pend[c])
            );

            if (c >= NUM_CORES) begin : g_idle_chk
                AST_IDLE_CORE_QUIET: assert property (@(posedge clk) disable iff (rst)
                    (pend[c*SRC_PER_CORE +: SRC_PER_CORE] == '0) && !any_pend[c]); // R7
            end
        end
    endgenerate

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pend == '0) && (any_pend == '0)); // R1

endmodule

// File: tb/pti_edge_capture_tb.sv
module pti_edge_capture_tb;

    localparam int CORES = 3;
    localparam int NV    = 19;

    // {src_lvl, clr_req, expected pend}
    localparam logic [23:0] VECS [NV] = '{
        24'h00_00_00,  // 0  R1 quiet after reset
        24'h01_00_01,  // 1  R2 core0 timer rises
        24'h01_00_01,  // 2  R4 held
        24'h00_00_01,  // 3  R4 fall has no effect
        24'h00_01_00,  // 4  R8 clear
        24'h02_00_02,  // 5  R5 core0 watchdog -> bit1
        24'h12_00_12,  // 6  R5 core2 timer -> bit4
        24'h12_02_10,  // 7  R8 clear only bit1
        24'h12_00_10,  // 8  R3 high level does not re-set
        24'h00_10_00,  // 9  R8
        24'h20_00_20,  // 10 R5 core2 watchdog -> bit5
        24'hC0_00_20,  // 11 R7 core3 unwired
        24'h00_C0_20,  // 12 R7 core3 clears ignored
        24'h0C_20_0C,  // 13 R5 core1 both
        24'h08_04_08,  // 14 R8
        24'h0C_04_0C,  // 15 R9 clear and rise together
        24'h00_0C_00,  // 16 R8
        24'h3F_00_3F,  // 17 R2 all live sources
        24'hFF_3F_00   // 18 R3 held high, R7 bits 7:6
    };
    localparam int VREQ [NV] = '{1,2,4,4,8,5,5,8,3,8,5,7,7,5,8,9,8,2,3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_lvl = '0;
    logic [7:0] clr_req = '0;
    logic [7:0] pend;
    logic [3:0] any_pend;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pti_edge_capture #(.NUM_CORES(CORES)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .src_lvl  (src_lvl),
        .clr_req  (clr_req),
        .pend     (pend),
        .any_pend (any_pend)
    );

    function automatic logic [3:0] any_of(input logic [7:0] p);
        logic [3:0] a;
        for (int c = 0; c < 4; c++) a[c] = p[2*c] | p[2*c+1];
        return a;
    endfunction

    task automatic check(input int req, input logic [7:0] exp);
        checks++;
        if (pend !== exp) begin
            errors++;
            $display("FAIL R%0d pend actual %h expected %h", req, pend, exp);
        end
        checks++;
        if (any_pend !== any_of(exp)) begin  // R10
            errors++;
            $display("FAIL R10 (with R%0d) any_pend actual %h expected %h",
                     req, any_pend, any_of(exp));
        end
    endtask

    task automatic step(input logic [7:0] l, input logic [7:0] c);
        src_lvl = l;
        clr_req = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 8'h00);                 // R1 reset state
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            step(VECS[v][23:16], VECS[v][15:8]);
            check(VREQ[v], VECS[v][7:0]);
        end

        // R6: previous level tracked every cycle, so fall then rise re-arms
        step(8'h00, 8'h00); check(6, 8'h00);
        step(8'h01, 8'h00); check(6, 8'h01);
        step(8'h01, 8'h01); check(6, 8'h00);
        step(8'h00, 8'h00); check(6, 8'h00);
        step(8'h01, 8'h00); check(6, 8'h01);

        // R1: reset clears pending and history; high level after release is an edge
        step(8'h02, 8'h01); check(5, 8'h02);
        rst = 1'b1;
        step(8'h02, 8'h00); check(1, 8'h00);
        step(8'h02, 8'h00); check(1, 8'h00);
        rst = 1'b0;
        step(8'h02, 8'h00); check(1, 8'h02);
        step(8'h02, 8'h00); check(3, 8'h02);

        finish_run();
    end

endmodule